// File: doc/BRIEF.md
# Operand Collector and Branch Target Unit

This block is the back half of an instruction decoder for an 8-bit microcontroller core with a 16-bit program address space. The front half classifies the opcode and hands the block a decoded descriptor. The descriptor carries a count of 0, 1 or 2 operand bytes still owed, a target kind, the start address of the instruction, the opcode byte, a branch-condition flag evaluated elsewhere, the accumulator and data-pointer values, and an opaque control word. The block then draws exactly the owed number of bytes from the fetch byte stream. It presents the assembled operands, the control word and the next-instruction address to the operand-fetch stage.

For branch kinds, the block forms the jump target in one of four ways. A relative target is a signed 8-bit offset added to the next-instruction address. An in-page target replaces the low 11 bits of the next-instruction address. A long target is a full 16-bit address. An indexed target is the data pointer plus the accumulator. When the condition flag says the branch is taken, the block issues a redirect to the fetch unit. While operand bytes are still owed, the block refuses the next descriptor, so the front half cannot decode a new opcode early.

Top module: `opnd_branch_unit`

## Requirements
- R1: `dec_ready` is high when the block is idle. It stays low from the cycle after a descriptor with a nonzero byte count is accepted until the last operand byte of that instruction is taken.
- R2: After accepting a descriptor with count N (0, 1 or 2), the block takes exactly N bytes, one per cycle in which `byte_valid` and `byte_ready` are both high. `byte_ready` is low while idle, and a byte offered then is ignored. Stall cycles between bytes lose nothing.
- R3: `out_valid` pulses for one cycle, registered at the edge where the instruction completes: the accept edge for N=0, or the edge that takes the last byte. At that time, `out_op1` is the first operand byte, `out_op2` is the second operand byte, unused operand bytes read 0, and `out_ctrl` equals the accepted `dec_ctrl`.
- R4: `out_npc` equals `dec_pc + 1 + N`, modulo 2^16.
- R5: For kind 1 (relative), the target is the next-instruction address plus the sign-extended last operand byte, modulo 2^16.
- R6: For kind 2 (in-page), the target is {next-instruction address bits 15:11, opcode bits 7:5, first operand byte}.
- R7: For kind 3 (long), the target is {first operand byte, second operand byte}, high byte first.
- R8: For kind 4 (indexed), the target is the data pointer plus the zero-extended accumulator, modulo 2^16.
- R9: `redir_valid` is high together with `out_valid` exactly when the instruction's kind is not 0 (none) and its `dec_cond` was 1. `redir_pc` then holds the target.
- R10: After reset, `out_valid`, `redir_valid` and `byte_ready` are low and `dec_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dec_valid | input | 1 | Descriptor offered |
| dec_ready | output | 1 | Descriptor may be accepted |
| dec_nbytes | input | 2 | Operand bytes owed (0..2) |
| dec_kind | input | 3 | Target kind: 0 none, 1 relative, 2 in-page, 3 long, 4 indexed |
| dec_pc | input | 16 | Instruction start address |
| dec_opc | input | 8 | Opcode byte |
| dec_cond | input | 1 | Branch taken flag |
| dec_acc | input | 8 | Accumulator value |
| dec_dptr | input | 16 | Data pointer value |
| dec_ctrl | input | 16 | Control word passed onward |
| byte_valid | input | 1 | Fetch byte offered |
| byte_data | input | 8 | Fetch byte |
| byte_ready | output | 1 | Fetch byte taken this cycle if valid |
| out_valid | output | 1 | Operand/control bundle valid (one cycle) |
| out_ctrl | output | 16 | Control word |
| out_op1 | output | 8 | First operand byte |
| out_op2 | output | 8 | Second operand byte |
| out_npc | output | 16 | Next-instruction address |
| redir_valid | output | 1 | Taken-branch redirect |
| redir_pc | output | 16 | New program counter |

## Verification
The assertions assume that the front half never offers a byte count above 2. They also assume that the descriptor fields stay meaningful only in the cycle in which the descriptor is accepted. The stimulus drives only counts 0, 1 and 2, and it changes descriptor fields solely on the falling edge before an offer. Byte offers are made only while a byte is owed, except for one deliberate offer while idle, which the block must ignore. Stall gaps are placed between the two operand bytes of the long and three-byte relative forms.

// File: rtl/obu_pkg.sv
package obu_pkg;
    localparam int ADDR_W = 16;
    localparam int BYTE_W = 8;
    localparam int PAGE_W = 11;

    typedef enum logic [2:0] {
        TK_NONE = 3'd0,
        TK_REL  = 3'd1,
        TK_ABS  = 3'd2,
        TK_LONG = 3'd3,
        TK_IDX  = 3'd4
    } tgt_kind_e;

    typedef enum logic [0:0] {
        ST_IDLE    = 1'b0,
        ST_COLLECT = 1'b1
    } seq_e;
endpackage

// File: rtl/obu_npc.sv
module obu_npc
    import obu_pkg::*;
#(
    parameter int AW = ADDR_W
) (
    input  logic [AW-1:0] start_pc,
    input  logic [1:0]    nbytes,
    output logic [AW-1:0] next_pc
);
    // Instruction length is the opcode byte plus the owed operand bytes.
    localparam int LEN_W = 3;
    logic [LEN_W-1:0] len;

    always_comb begin
        len     = LEN_W'(nbytes) + LEN_W'(1);
        next_pc = start_pc + AW'(len);
    end
endmodule

// File: rtl/obu_target.sv
module obu_target
    import obu_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BYTE_W
) (
    input  tgt_kind_e     kind,
    input  logic [1:0]    nbytes,
    input  logic [AW-1:0] next_pc,
    input  logic [BW-1:0] opcode,
    input  logic [BW-1:0] op1,
    input  logic [BW-1:0] op2,
    input  logic [BW-1:0] acc,
    input  logic [AW-1:0] dptr,
    output logic [AW-1:0] target
);
    localparam int OPC_HI_W = PAGE_W - BW;

    logic [BW-1:0] rel_off;
    logic [AW-1:0] rel_sext;

    always_comb begin
        // The relative offset is always the final operand byte.
        rel_off  = (nbytes == 2'd2) ? op2 : op1;
        rel_sext = {{(AW-BW){rel_off[BW-1]}}, rel_off};
        unique case (kind)
            TK_REL:  target = next_pc + rel_sext;
            TK_ABS:  target = {next_pc[AW-1:PAGE_W], opcode[BW-1 -: OPC_HI_W], op1};
            TK_LONG: target = AW'({op1, op2});
            TK_IDX:  target = dptr + AW'(acc);
            default: target = next_pc;
        endcase
    end
endmodule

// File: rtl/opnd_branch_unit.sv
module opnd_branch_unit
    import obu_pkg::*;
#(
    parameter int CTRL_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    output logic              dec_ready,
    input  logic [1:0]        dec_nbytes,
    input  logic [2:0]        dec_kind,
    input  logic [15:0]       dec_pc,
    input  logic [7:0]        dec_opc,
    input  logic              dec_cond,
    input  logic [7:0]        dec_acc,
    input  logic [15:0]       dec_dptr,
    input  logic [CTRL_W-1:0] dec_ctrl,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              byte_ready,
    output logic              out_valid,
    output logic [CTRL_W-1:0] out_ctrl,
    output logic [7:0]        out_op1,
    output logic [7:0]        out_op2,
    output logic [15:0]       out_npc,
    output logic              redir_valid,
    output logic [15:0]       redir_pc
);
    localparam int AW = ADDR_W;
    localparam int BW = BYTE_W;

    typedef struct packed {
        seq_e              st;
        logic [1:0]        need;
        logic [1:0]        nb;
        logic [BW-1:0]     b1;
        tgt_kind_e         kind;
        logic [AW-1:0]     npc;
        logic [BW-1:0]     opc;
        logic              cond;
        logic [BW-1:0]     acc;
        logic [AW-1:0]     dptr;
        logic [CTRL_W-1:0] ctrl;
        logic              ov;
        logic [BW-1:0]     op1;
        logic [BW-1:0]     op2;
        logic [AW-1:0]     onpc;
        logic [CTRL_W-1:0] octrl;
        logic              rv;
        logic [AW-1:0]     rpc;
    } state_t;

    state_t s_d, s_q;

    logic          dec_fire, byte_fire, finish;
    tgt_kind_e     cur_kind;
    logic [1:0]    cur_nb;
    logic [AW-1:0] cur_npc, in_npc, tgt;
    logic [BW-1:0] cur_opc, cur_acc, fin_b1, fin_b2;
    logic [AW-1:0] cur_dptr;
    logic          cur_cond;
    logic [CTRL_W-1:0] cur_ctrl;

    assign dec_ready  = (s_q.st == ST_IDLE);
    assign byte_ready = (s_q.st == ST_COLLECT);
    assign dec_fire   = dec_valid && dec_ready;
    assign byte_fire  = byte_valid && byte_ready;

    obu_npc #(.AW(AW)) u_npc (
        .start_pc (dec_pc),
        .nbytes   (dec_nbytes),
        .next_pc  (in_npc)
    );

    // Select either the arriving descriptor or the held one.
    always_comb begin
        if (dec_fire) begin
            cur_kind = tgt_kind_e'(dec_kind);
            cur_nb   = dec_nbytes;
            cur_npc  = in_npc;
            cur_opc  = dec_opc;
            cur_acc  = dec_acc;
            cur_dptr = dec_dptr;
            cur_cond = dec_cond;
            cur_ctrl = dec_ctrl;
            fin_b1   = '0;
            fin_b2   = '0;
        end else begin
            cur_kind = s_q.kind;
            cur_nb   = s_q.nb;
            cur_npc  = s_q.npc;
            cur_opc  = s_q.opc;
            cur_acc  = s_q.acc;
            cur_dptr = s_q.dptr;
            cur_cond = s_q.cond;
            cur_ctrl = s_q.ctrl;
            fin_b1   = (s_q.nb == 2'd2) ? s_q.b1 : byte_data;
            fin_b2   = (s_q.nb == 2'd2) ? byte_data : '0;
        end
        finish = (dec_fire && dec_nbytes == 2'd0) ||
                 (byte_fire && s_q.need == 2'd1);
    end

    obu_target #(.AW(AW), .BW(BW)) u_tgt (
        .kind    (cur_kind),
        .nbytes  (cur_nb),
        .next_pc (cur_npc),
        .opcode  (cur_opc),
        .op1     (fin_b1),
        .op2     (fin_b2),
        .acc     (cur_acc),
        .dptr    (cur_dptr),
        .target  (tgt)
    );

    always_comb begin
        s_d    = s_q;
        s_d.ov = 1'b0;
        s_d.rv = 1'b0;
        if (dec_fire) begin
            s_d.kind = tgt_kind_e'(dec_kind);
            s_d.nb   = dec_nbytes;
            s_d.need = dec_nbytes;
            s_d.npc  = in_npc;
            s_d.opc  = dec_opc;
            s_d.cond = dec_cond;
            s_d.acc  = dec_acc;
            s_d.dptr = dec_dptr;
            s_d.ctrl = dec_ctrl;
            s_d.b1   = '0;
            if (dec_nbytes != 2'd0) s_d.st = ST_COLLECT;
        end
        if (byte_fire) begin
            s_d.need = s_q.need - 2'd1;
            if (s_q.need == 2'd2) s_d.b1 = byte_data;
            if (s_q.need == 2'd1) s_d.st = ST_IDLE;
        end
        if (finish) begin
            s_d.ov    = 1'b1;
            s_d.op1   = fin_b1;
            s_d.op2   = fin_b2;
            s_d.onpc  = cur_npc;
            s_d.octrl = cur_ctrl;
            s_d.rv    = cur_cond && (cur_kind != TK_NONE);
            s_d.rpc   = tgt;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign out_valid   = s_q.ov;
    assign out_ctrl    = s_q.octrl;
    assign out_op1     = s_q.op1;
    assign out_op2     = s_q.op2;
    assign out_npc     = s_q.onpc;
    assign redir_valid = s_q.rv;
    assign redir_pc    = s_q.rpc;

    // R9
    redir_with_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redir_valid |-> out_valid);

    // R3
    out_has_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(dec_fire || byte_fire));

    // R1
    hold_off_decode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_fire |=> (out_valid || !dec_ready));

    // R2
    byte_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_fire |-> !dec_ready);

    // R2
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_nbytes <= 2'd2));
endmodule

// File: tb/opnd_branch_unit_test.sv
module opnd_branch_unit_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0;
    logic dec_ready;
    logic [1:0] dec_nbytes = '0;
    logic [2:0] dec_kind = '0;
    logic [15:0] dec_pc = '0;
    logic [7:0] dec_opc = '0;
    logic dec_cond = 1'b0;
    logic [7:0] dec_acc = '0;
    logic [15:0] dec_dptr = '0;
    logic [15:0] dec_ctrl = '0;
    logic byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic byte_ready, out_valid, redir_valid;
    logic [15:0] out_ctrl, out_npc, redir_pc;
    logic [7:0] out_op1, out_op2;

    int checks = 0;
    int fails = 0;
    int cyc = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    opnd_branch_unit uut (.*);

    typedef struct packed {
        logic [2:0]  kind;
        logic [1:0]  nb;
        logic [15:0] pc;
        logic [7:0]  opc;
        logic [7:0]  b1;
        logic [7:0]  b2;
        logic [7:0]  acc;
        logic [15:0] dptr;
        logic        cond;
        logic [15:0] enpc;
        logic [15:0] etgt;
        logic        etaken;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 2'd0, 16'h0100, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h0101, 16'h0000, 1'b0},
        '{3'd1, 2'd1, 16'h0200, 8'h80, 8'h10, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h0202, 16'h0212, 1'b1},
        '{3'd1, 2'd1, 16'h0200, 8'h80, 8'hFE, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h0202, 16'h0200, 1'b1},
        '{3'd1, 2'd2, 16'h1000, 8'hB4, 8'h55, 8'h80, 8'h00, 16'h0000, 1'b1, 16'h1003, 16'h0F83, 1'b1},
        '{3'd1, 2'd1, 16'h0300, 8'h60, 8'h05, 8'h00, 8'h00, 16'h0000, 1'b0, 16'h0302, 16'h0000, 1'b0},
        '{3'd2, 2'd1, 16'h27FE, 8'hE1, 8'h34, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h2800, 16'h2F34, 1'b1},
        '{3'd2, 2'd1, 16'h1234, 8'h21, 8'hAB, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h1236, 16'h11AB, 1'b1},
        '{3'd3, 2'd2, 16'h0050, 8'h02, 8'hBE, 8'hEF, 8'h00, 16'h0000, 1'b1, 16'h0053, 16'hBEEF, 1'b1},
        '{3'd4, 2'd0, 16'h0400, 8'h73, 8'h00, 8'h00, 8'h80, 16'hFFA0, 1'b1, 16'h0401, 16'h0020, 1'b1},
        '{3'd1, 2'd1, 16'hFFFE, 8'h80, 8'h01, 8'h00, 8'h00, 16'h0000, 1'b1, 16'h0000, 16'h0001, 1'b1},
        '{3'd1, 2'd2, 16'hFFFF, 8'hB5, 8'h00, 8'h7F, 8'h00, 16'h0000, 1'b1, 16'h0002, 16'h0081, 1'b1},
        '{3'd3, 2'd2, 16'h0700, 8'h02, 8'h12, 8'h34, 8'h00, 16'h0000, 1'b0, 16'h0703, 16'h0000, 1'b0}
    };

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string tgt_req(input logic [2:0] k);
        case (k)
            3'd1: return "R5";
            3'd2: return "R6";
            3'd3: return "R7";
            default: return "R8";
        endcase
    endfunction

    task automatic run(input vec_t v, input int idx);
        @(negedge clk);
        chk(dec_ready == 1'b1, "R1 idle ready", dec_ready, 1);
        dec_valid = 1'b1; dec_nbytes = v.nb; dec_kind = v.kind; dec_pc = v.pc;
        dec_opc = v.opc; dec_cond = v.cond; dec_acc = v.acc; dec_dptr = v.dptr;
        dec_ctrl = 16'(idx + 16'hA000);
        @(posedge clk);
        @(negedge clk);
        dec_valid = 1'b0;
        if (v.nb != 2'd0) begin
            chk(dec_ready == 1'b0, "R1 held off", dec_ready, 0);
            chk(byte_ready == 1'b1, "R2 byte ready", byte_ready, 1);
            byte_valid = 1'b1; byte_data = v.b1;
            @(posedge clk);
            @(negedge clk);
            byte_valid = 1'b0;
            if (v.nb == 2'd2) begin
                chk(out_valid == 1'b0, "R2 awaits second", out_valid, 0);
                chk(dec_ready == 1'b0, "R1 held off", dec_ready, 0);
                @(posedge clk);
                @(negedge clk);
                chk(out_valid == 1'b0, "R2 stall", out_valid, 0);
                byte_valid = 1'b1; byte_data = v.b2;
                @(posedge clk);
                @(negedge clk);
                byte_valid = 1'b0;
            end
        end
        chk(out_valid == 1'b1, "R3 out pulse", out_valid, 1);
        chk(out_ctrl == 16'(idx + 16'hA000), "R3 ctrl", out_ctrl, idx + 16'hA000);
        chk(out_op1 == ((v.nb != 0) ? v.b1 : 8'h00), "R3 op1", out_op1, v.b1);
        chk(out_op2 == ((v.nb == 2) ? v.b2 : 8'h00), "R3 op2", out_op2, v.b2);
        chk(out_npc == v.enpc, "R4 npc", out_npc, v.enpc);
        chk(redir_valid == v.etaken, "R9 redirect", redir_valid, v.etaken);
        if (v.etaken)
            chk(redir_pc == v.etgt, tgt_req(v.kind), redir_pc, v.etgt);
        @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R3 single pulse", out_valid, 0);
        chk(redir_valid == 1'b0, "R9 single pulse", redir_valid, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual %0d expected below 20000", cyc);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10 reset values
        chk(out_valid == 1'b0, "R10 out_valid", out_valid, 0);
        chk(redir_valid == 1'b0, "R10 redir_valid", redir_valid, 0);
        chk(byte_ready == 1'b0, "R10 byte_ready", byte_ready, 0);
        chk(dec_ready == 1'b1, "R10 dec_ready", dec_ready, 1);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) run(VEC[i], i);

        // R2: byte offered while idle is ignored; later byte is the operand
        @(negedge clk);
        byte_valid = 1'b1; byte_data = 8'h99;
        chk(byte_ready == 1'b0, "R2 idle byte refused", byte_ready, 0);
        @(posedge clk);
        @(negedge clk);
        byte_valid = 1'b0;
        chk(out_valid == 1'b0, "R2 idle byte no output", out_valid, 0);
        run('{3'd1, 2'd1, 16'h0010, 8'h80, 8'h04, 8'h00, 8'h00, 16'h0000, 1'b1,
              16'h0012, 16'h0016, 1'b1}, 20);

        // R1: back-to-back zero-byte instructions accepted on consecutive cycles
        @(negedge clk);
        dec_valid = 1'b1; dec_nbytes = 2'd0; dec_kind = 3'd4; dec_pc = 16'h0800;
        dec_cond = 1'b1; dec_acc = 8'h01; dec_dptr = 16'h1000;
        @(posedge clk);
        @(negedge clk);
        chk(dec_ready == 1'b1, "R1 ready after zero-byte", dec_ready, 1);
        chk(redir_pc == 16'h1001, "R8 first", redir_pc, 16'h1001);
        dec_acc = 8'hFF;
        @(posedge clk);
        @(negedge clk);
        dec_valid = 1'b0;
        chk(out_valid == 1'b1, "R3 second pulse", out_valid, 1);
        chk(redir_pc == 16'h10FF, "R8 second", redir_pc, 16'h10FF);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule